// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit is the operand-fetch and address-generation stage of a small 8-bit processor that addresses a flat 16-bit space. Memory, I/O and control registers all live in that one space, so every address it forms is 16 bits wide and goes out on a single byte-wide read port. The decoder hands it a primary addressing mode, an optional secondary step, the program counter that points just past the opcode, and a branch condition. The unit then reads the operand bytes that follow the opcode and returns an immediate value, an effective data address, a second (destination) address, or a new program counter.

The primary mode is one of inherent, 8-bit immediate, 16-bit immediate, direct-page or relative. The secondary step covers two cases. Test-and-branch instructions resolve their tested operand and then read a branch offset. Move-type instructions compute a source address and then a destination address. Memory reads have a fixed latency of one cycle: each byte costs one cycle to present the address and one cycle to capture the data.

Top module: `opaddr_unit`

## Requirements
- R1: A request is accepted on a rising edge where both req_valid_i and req_ready_o are high. req_ready_o is high only while the unit is idle, so it is low from the cycle after acceptance through the done cycle, and a request presented while busy is ignored.
- R2: done_o is high for exactly one cycle per accepted request. operand_o, ea_o, ea2_o and pc_o hold their values from that cycle until the next request is accepted.
- R3: For each operand byte, mem_rd_o is high for one cycle with mem_addr_o equal to the current fetch pointer, and the byte is taken from mem_rdata_i in the following cycle. A request that fetches N bytes therefore raises done_o 2N clock edges after the accepting edge and makes exactly N reads.
- R4: Mode 0 (inherent), and the unused modes 5 to 7, read no primary bytes. With no secondary step, done_o rises right after the accepting edge, no read is made and pc_o equals pc_i.
- R5: Mode 1 (8-bit immediate) reads one byte and returns it zero-extended on operand_o.
- R6: Mode 2 (16-bit immediate) reads two bytes. The first byte read goes to operand_o[15:8] and the second to operand_o[7:0].
- R7: Mode 3 (direct) reads one byte b and returns ea_o = {8'h00, b}, which always lies in 0x0000 to 0x00FF.
- R8: The fetch pointer advances by one for every byte read. When no branch offset is taken, pc_o ends at pc_i plus the number of bytes read.
- R9: Mode 4 (relative) reads a signed offset byte. If cond_i is high when that byte is captured, pc_o = (address of the offset byte + 1) + sign-extended offset, modulo 65536.
- R10: If cond_i is low when an offset byte is captured, pc_o is the address just past the offset byte.
- R11: sec_i = 1 (branch) fetches one relative offset after all primary bytes, with the R9/R10 rule applied from the pointer after that offset. The primary operand or address stays valid alongside it. sec_i values 0 and 3 add no step.
- R12: sec_i = 2 (destination) fetches one more byte b after the primary bytes and returns ea2_o = {8'h00, b}, leaving the primary ea_o or operand_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit idle, request can be accepted |
| mode_i | input | 3 | Primary addressing mode |
| sec_i | input | 2 | Secondary step: 0 none, 1 branch offset, 2 destination direct address |
| pc_i | input | 16 | Address of the first byte after the opcode |
| cond_i | input | 1 | Branch condition, sampled when an offset byte is captured |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the strobe |
| done_o | output | 1 | One-cycle completion pulse |
| operand_o | output | 16 | Immediate operand value |
| ea_o | output | 16 | Primary effective address |
| ea2_o | output | 16 | Destination effective address |
| pc_o | output | 16 | Program counter after the operand bytes, or branch target |

## Verification
The assertions check on every cycle that done is a single pulse, that reads are never back to back and are always followed by a capture, and that acceptance drops ready. They also check that an inherent request finishes at once without a read, that a non-offset byte steps the pointer by exactly one, that a false condition gives the plain step, and that results hold between events. Only the bench scenarios can show the values themselves: the byte order of 16-bit immediates, the zero page for direct addresses, the signed offset arithmetic including wrap past 0xFFFF, the ordering of the secondary step, and the exact cycle counts for each mode.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  localparam logic [2:0] AM_INH   = 3'd0;
  localparam logic [2:0] AM_IMM8  = 3'd1;
  localparam logic [2:0] AM_IMM16 = 3'd2;
  localparam logic [2:0] AM_DIR   = 3'd3;
  localparam logic [2:0] AM_REL   = 3'd4;

  localparam logic [1:0] SEC_NONE   = 2'd0;
  localparam logic [1:0] SEC_BRANCH = 2'd1;
  localparam logic [1:0] SEC_DEST   = 2'd2;

  typedef enum logic [2:0] {
    ROLE_IMM8,
    ROLE_IMM_HI,
    ROLE_IMM_LO,
    ROLE_DIR,
    ROLE_DIR2,
    ROLE_OFF
  } role_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPT,
    ST_DONE
  } st_e;

  // primary operand bytes per mode
  function automatic logic [1:0] prim_len(input logic [2:0] m);
    case (m)
      AM_IMM8:  prim_len = 2'd1;
      AM_IMM16: prim_len = 2'd2;
      AM_DIR:   prim_len = 2'd1;
      AM_REL:   prim_len = 2'd1;
      default:  prim_len = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] sec_len(input logic [1:0] s);
    sec_len = (s == SEC_BRANCH || s == SEC_DEST) ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/opaddr_seq.sv
module opaddr_seq
  import opaddr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] mode_i,
  input  logic [1:0] sec_i,
  output logic       req_ready_o,
  output logic       accept_o,
  output logic       mem_rd_o,
  output logic       cap_o,
  output role_e      role_o,
  output logic       done_o
);

  st_e        st_q, st_d;
  logic [2:0] mode_q;
  logic [1:0] sec_q;
  logic [1:0] idx_q, idx_d;
  logic       phase_q, phase_d;   // 0 primary, 1 secondary

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign mem_rd_o    = (st_q == ST_ISSUE);
  assign cap_o       = (st_q == ST_CAPT);
  assign done_o      = (st_q == ST_DONE);

  always_comb begin
    if (phase_q) begin
      role_o = (sec_q == SEC_BRANCH) ? ROLE_OFF : ROLE_DIR2;
    end else begin
      case (mode_q)
        AM_IMM8:  role_o = ROLE_IMM8;
        AM_IMM16: role_o = (idx_q == 2'd0) ? ROLE_IMM_HI : ROLE_IMM_LO;
        AM_DIR:   role_o = ROLE_DIR;
        default:  role_o = ROLE_OFF;
      endcase
    end
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    phase_d = phase_q;
    case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          idx_d = 2'd0;
          if (prim_len(mode_i) != 2'd0) begin
            phase_d = 1'b0;
            st_d    = ST_ISSUE;
          end else if (sec_len(sec_i) != 2'd0) begin
            phase_d = 1'b1;
            st_d    = ST_ISSUE;
          end else begin
            phase_d = 1'b0;
            st_d    = ST_DONE;
          end
        end
      end
      ST_ISSUE: st_d = ST_CAPT;
      ST_CAPT: begin
        if (!phase_q && (idx_q + 2'd1) < prim_len(mode_q)) begin
          idx_d = idx_q + 2'd1;
          st_d  = ST_ISSUE;
        end else if (!phase_q && sec_len(sec_q) != 2'd0) begin
          idx_d   = 2'd0;
          phase_d = 1'b1;
          st_d    = ST_ISSUE;
        end else begin
          st_d = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= 2'd0;
      phase_q <= 1'b0;
      mode_q  <= AM_INH;
      sec_q   <= SEC_NONE;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
      if (accept_o) begin
        mode_q <= mode_i;
        sec_q  <= sec_i;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R2
  AST_RD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (!mem_rd_o && cap_o)) else $error("read not followed by capture"); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !req_ready_o) else $error("ready after accept"); // R1
  AST_INH_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && prim_len(mode_i) == 2'd0 && sec_len(sec_i) == 2'd0) |=> (done_o && !mem_rd_o))
    else $error("inherent request not immediate"); // R4

endmodule

// File: rtl/opaddr_agen.sv
module opaddr_agen #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [ADDR_W-1:0] pc_inc_o,
  output logic [ADDR_W-1:0] pc_tgt_o,
  output logic [ADDR_W-1:0] page_o
);

  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] off_sext;

  assign pc_inc_o = pc_i + ADDR_W'(1);
  assign off_sext = {{PAD_W{byte_i[DATA_W-1]}}, byte_i};
  assign pc_tgt_o = pc_inc_o + off_sext;   // wraps modulo 2**ADDR_W
  assign page_o   = {{PAD_W{1'b0}}, byte_i};

endmodule

// File: rtl/opaddr_dp.sv
module opaddr_dp
  import opaddr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                accept_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic                cap_i,
  input  role_e               role_i,
  input  logic [DATA_W-1:0]   byte_i,
  input  logic                cond_i,
  input  logic [ADDR_W-1:0]   pc_inc_i,
  input  logic [ADDR_W-1:0]   pc_tgt_i,
  input  logic [ADDR_W-1:0]   page_i,
  output logic [2*DATA_W-1:0] operand_o,
  output logic [ADDR_W-1:0]   ea_o,
  output logic [ADDR_W-1:0]   ea2_o,
  output logic [ADDR_W-1:0]   pc_o
);

  localparam int LANES = 2;

  logic [ADDR_W-1:0] pc_q, ea_q, ea2_q;

  // operand byte lanes; top lane takes the first byte of a wide immediate
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    logic              wr_hi, wr_lo, wr_n8;
    assign wr_hi = (role_i == ROLE_IMM_HI) && (l == LANES - 1);
    assign wr_lo = (role_i == ROLE_IMM_LO || role_i == ROLE_IMM8) && (l == 0);
    assign wr_n8 = (role_i == ROLE_IMM8) && (l != 0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (accept_i) begin
        lane_q <= '0;
      end else if (cap_i) begin
        if (wr_hi || wr_lo) lane_q <= byte_i;
        else if (wr_n8)     lane_q <= '0;
      end
    end
    assign operand_o[l*DATA_W +: DATA_W] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ea_q  <= '0;
      ea2_q <= '0;
    end else if (accept_i) begin
      pc_q  <= pc_i;
      ea_q  <= '0;
      ea2_q <= '0;
    end else if (cap_i) begin
      if (role_i == ROLE_OFF && cond_i) pc_q <= pc_tgt_i;
      else                              pc_q <= pc_inc_i;
      if (role_i == ROLE_DIR)  ea_q  <= page_i;
      if (role_i == ROLE_DIR2) ea2_q <= page_i;
    end
  end

  assign pc_o  = pc_q;
  assign ea_o  = ea_q;
  assign ea2_o = ea2_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !accept_i && role_i != ROLE_OFF) |=> (pc_q == $past(pc_q) + ADDR_W'(1)))
    else $error("pointer did not step by one"); // R8
  AST_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !accept_i && role_i == ROLE_OFF && !cond_i) |=> (pc_q == $past(pc_q) + ADDR_W'(1)))
    else $error("untaken branch moved pointer"); // R10
  AST_DIR_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !accept_i && role_i == ROLE_DIR) |=> (ea_q[ADDR_W-1:DATA_W] == '0))
    else $error("direct address left page zero"); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !cap_i) |=> ($stable(pc_q) && $stable(ea_q) && $stable(ea2_q) && $stable(operand_o)))
    else $error("result changed while idle"); // R2

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [2:0]          mode_i,
  input  logic [1:0]          sec_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic                cond_i,
  output logic                mem_rd_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                done_o,
  output logic [2*DATA_W-1:0] operand_o,
  output logic [ADDR_W-1:0]   ea_o,
  output logic [ADDR_W-1:0]   ea2_o,
  output logic [ADDR_W-1:0]   pc_o
);

  logic              accept, cap;
  role_e             role;
  logic [ADDR_W-1:0] pc_cur, pc_inc, pc_tgt, page;

  opaddr_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .mode_i      (mode_i),
    .sec_i       (sec_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .mem_rd_o    (mem_rd_o),
    .cap_o       (cap),
    .role_o      (role),
    .done_o      (done_o)
  );

  opaddr_agen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_agen (
    .pc_i     (pc_cur),
    .byte_i   (mem_rdata_i),
    .pc_inc_o (pc_inc),
    .pc_tgt_o (pc_tgt),
    .page_o   (page)
  );

  opaddr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .pc_i      (pc_i),
    .cap_i     (cap),
    .role_i    (role),
    .byte_i    (mem_rdata_i),
    .cond_i    (cond_i),
    .pc_inc_i  (pc_inc),
    .pc_tgt_i  (pc_tgt),
    .page_i    (page),
    .operand_o (operand_o),
    .ea_o      (ea_o),
    .ea2_o     (ea2_o),
    .pc_o      (pc_cur)
  );

  assign mem_addr_o = pc_cur;
  assign pc_o       = pc_cur;

endmodule

// File: tb/opaddr_unit_tb.sv
`timescale 1ns/1ps
module opaddr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  mode = 3'd0;
  logic [1:0]  sec = 2'd0;
  logic [15:0] pc_in = 16'h0;
  logic        cond = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        done;
  logic [15:0] operand, ea, ea2, pc_out;

  logic [7:0]  mem [0:255];
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  opaddr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .mode_i(mode), .sec_i(sec), .pc_i(pc_in), .cond_i(cond),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .done_o(done), .operand_o(operand), .ea_o(ea), .ea2_o(ea2), .pc_o(pc_out)
  );

  // one-cycle-latency read model
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request, count cycles to done and reads; optionally poke a second request while busy
  task automatic run(input logic [2:0] m, input logic [1:0] s, input logic [15:0] pc,
                     input logic c, input int exp_cyc, input int exp_rd, input bit poke,
                     input string tag);
    int cyc = 0;
    int rd = 0;
    int busy_rdy = 0;
    @(negedge clk);
    req_valid = 1'b1; mode = m; sec = s; pc_in = pc; cond = c;
    @(negedge clk);
    if (poke) begin
      mode = 3'd0; sec = 2'd0; pc_in = 16'h7777;
    end else begin
      req_valid = 1'b0;
    end
    while (!done && cyc < 100) begin
      if (mem_rd) rd++;
      if (req_ready) busy_rdy++;
      cyc++;
      @(negedge clk);
    end
    if (req_ready) busy_rdy++;
    req_valid = 1'b0;
    chk(16'(cyc), 16'(exp_cyc), {tag, " R3 cycles to done"});
    chk(16'(rd), 16'(exp_rd), {tag, " R3 read count"});
    chk(16'(busy_rdy), 16'd0, {tag, " R1 ready while busy"});
    @(negedge clk);
    chk({15'd0, done}, 16'd0, {tag, " R2 done one cycle"});
    chk({15'd0, req_ready}, 16'd1, {tag, " R1 ready after done"});
  endtask

  task automatic t_reset();
    chk({15'd0, req_ready}, 16'd1, "R1 reset ready");
    chk({15'd0, done}, 16'd0, "R2 reset done");
    chk({15'd0, mem_rd}, 16'd0, "R3 reset read");
    chk(pc_out, 16'h0, "R2 reset pc");
    chk(operand, 16'h0, "R2 reset operand");
  endtask

  task automatic t_inherent();
    run(3'd0, 2'd0, 16'h1234, 1'b1, 0, 0, 0, "R4 inh");
    chk(pc_out, 16'h1234, "R4 inh pc");
    run(3'd6, 2'd0, 16'h4321, 1'b0, 0, 0, 0, "R4 reserved");
    chk(pc_out, 16'h4321, "R4 reserved pc");
  endtask

  task automatic t_imm8();
    mem[8'h40] = 8'hA5;
    run(3'd1, 2'd0, 16'h1240, 1'b0, 2, 1, 0, "R5 imm8");
    chk(operand, 16'h00A5, "R5 imm8 value");
    chk(pc_out, 16'h1241, "R8 imm8 pc");
  endtask

  task automatic t_imm16();
    mem[8'h50] = 8'h12; mem[8'h51] = 8'h34;
    run(3'd2, 2'd0, 16'h1250, 1'b0, 4, 2, 0, "R6 imm16");
    chk(operand, 16'h1234, "R6 imm16 order");
    chk(pc_out, 16'h1252, "R8 imm16 pc");
    // imm8 after imm16 must clear the high byte
    mem[8'h52] = 8'h7E;
    run(3'd1, 2'd0, 16'h1252, 1'b0, 2, 1, 0, "R5 imm8 after imm16");
    chk(operand, 16'h007E, "R5 zero-extend");
  endtask

  task automatic t_direct();
    mem[8'h60] = 8'h80;
    run(3'd3, 2'd0, 16'hC060, 1'b0, 2, 1, 0, "R7 dir");
    chk(ea, 16'h0080, "R7 dir page");
    chk(pc_out, 16'hC061, "R8 dir pc");
  endtask

  task automatic t_relative();
    mem[8'h70] = 8'h10;
    run(3'd4, 2'd0, 16'h2070, 1'b1, 2, 1, 0, "R9 rel fwd");
    chk(pc_out, 16'h2081, "R9 rel forward target");
    mem[8'h71] = 8'hF0;
    run(3'd4, 2'd0, 16'h2071, 1'b1, 2, 1, 0, "R9 rel back");
    chk(pc_out, 16'h2062, "R9 rel backward target");
    mem[8'hFE] = 8'h05;
    run(3'd4, 2'd0, 16'hFFFE, 1'b1, 2, 1, 0, "R9 rel wrap");
    chk(pc_out, 16'h0004, "R9 rel wrap target");
    run(3'd4, 2'd0, 16'h2070, 1'b0, 2, 1, 0, "R10 rel untaken");
    chk(pc_out, 16'h2071, "R10 untaken pc");
  endtask

  task automatic t_test_branch();
    mem[8'h80] = 8'h22; mem[8'h81] = 8'hFE;
    run(3'd3, 2'd1, 16'h3080, 1'b1, 4, 2, 0, "R11 dir+branch");
    chk(ea, 16'h0022, "R11 tested address kept");
    chk(pc_out, 16'h3080, "R11 offset from pointer after offset");
    mem[8'h90] = 8'h03;
    run(3'd0, 2'd1, 16'h3090, 1'b1, 2, 1, 0, "R11 inh+branch");
    chk(pc_out, 16'h3094, "R11 inh branch target");
    mem[8'h98] = 8'h44; mem[8'h99] = 8'h10;
    run(3'd1, 2'd1, 16'h3098, 1'b0, 4, 2, 0, "R11 imm+branch untaken");
    chk(operand, 16'h0044, "R11 compare operand kept");
    chk(pc_out, 16'h309A, "R10 R11 untaken pc");
    run(3'd3, 2'd3, 16'hC060, 1'b1, 2, 1, 0, "R11 sec code 3 none");
    chk(pc_out, 16'hC061, "R11 sec 3 no step");
  endtask

  task automatic t_move();
    mem[8'hA0] = 8'h11; mem[8'hA1] = 8'h99;
    run(3'd3, 2'd2, 16'h30A0, 1'b1, 4, 2, 0, "R12 dir+dest");
    chk(ea, 16'h0011, "R12 source address");
    chk(ea2, 16'h0099, "R12 destination address");
    chk(pc_out, 16'h30A2, "R12 R8 move pc");
    mem[8'hB0] = 8'h5C; mem[8'hB1] = 8'hE0;
    run(3'd1, 2'd2, 16'h30B0, 1'b0, 4, 2, 0, "R12 imm+dest");
    chk(operand, 16'h005C, "R12 immediate source");
    chk(ea2, 16'h00E0, "R12 immediate destination");
  endtask

  task automatic t_busy_ignore();
    mem[8'h50] = 8'h12; mem[8'h51] = 8'h34;
    run(3'd2, 2'd0, 16'h1250, 1'b0, 4, 2, 1, "R1 busy poke");
    chk(pc_out, 16'h1252, "R1 busy request ignored pc");
    chk(operand, 16'h1234, "R1 busy request ignored operand");
    repeat (3) @(negedge clk);
    chk({15'd0, done}, 16'd0, "R2 no stray done");
    chk(pc_out, 16'h1252, "R2 pc held while idle");
    chk(operand, 16'h1234, "R2 operand held while idle");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inherent();
    t_imm8();
    t_imm16();
    t_direct();
    t_relative();
    t_test_branch();
    t_move();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule